// File: doc/BRIEF.md
# Host configuration access translator

This block sits between a processor register-access port and the initiator of a PCI bus. Software first writes a configuration address register that names a bus, a device, a function and a configuration register, together with an enable bit. A later access anywhere inside the 4-byte configuration data window is then translated into a request for the bus initiator. The request carries a cycle kind, a bus command and a fully formatted address.

The bus number in the address register decides the cycle kind. A bus number that matches the local bus produces a type 0 configuration cycle, with a one-hot device select in the upper address bits. Any other bus number produces a type 1 cycle, which bridges further down the hierarchy forward unchanged. An all-ones device number on the local bus is reserved for special cycles. When the enable bit is clear, data window accesses complete locally. The host sees one response for each accepted access: either one cycle after acceptance, or one cycle after the initiator reports completion.

Top module: `cfgx_top`

## Requirements
- R1: After reset the address register reads as zero, no bus request is pending, no response is pending and `req_ready_o` is high.
- R2: A write to the address register window (byte offset 0x00–0x03) stores enable (bit 31), bus (bits 23:16), device (bits 15:11), function (bits 10:8) and register (bits 7:2). A read there returns these fields with all other bits zero, one cycle after acceptance.
- R3: With the enable bit clear, a data window access issues no bus request. A read returns 0xFFFFFFFF and a write is dropped. Either way the response comes one cycle after acceptance.
- R4: With enable set, bus equal to the local bus and device not all ones, a type 0 request (kind 0) is raised one cycle after acceptance. Its address has bit 11+device set for device 0..20 and no select bit for higher devices, function in bits 10:8, register in bits 7:2 and bits 1:0 = 00.
- R5: With enable set and bus different from the local bus, a type 1 request (kind 1) is raised. Its address is {8'h00, bus, device, function, register, 2'b01}, and this applies for every device number, all ones included.
- R6: Configuration requests use command 4'b1010 for reads and 4'b1011 for writes.
- R7: With enable set, bus local and device all ones, a write raises a special cycle request (kind 2) with command 4'b0001, address zero and the write data on `cyc_wdata_o`.
- R8: With enable set, bus local and device all ones, a read issues no request and returns 0xFFFFFFFF one cycle after acceptance.
- R9: A raised request holds kind, command, address and data stable until `cyc_done_i`, and `req_ready_o` stays low throughout.
- R10: One cycle after `cyc_done_i` the request drops and the response is valid. For reads it carries the `cyc_rdata_i` value sampled with done; for writes it carries zero.
- R11: Accesses outside both windows issue no request, read as zero and leave the address register unchanged.
- R12: Every byte offset in the 4-byte data window (0x04–0x07) triggers translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host access request |
| req_ready_o | output | 1 | Block can accept an access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | OFF_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | 32 | Response read data |
| cyc_valid_o | output | 1 | Request to bus initiator |
| cyc_kind_o | output | 2 | 0 type 0, 1 type 1, 2 special cycle |
| cyc_cmd_o | output | 4 | Bus command |
| cyc_addr_o | output | 32 | Formatted bus address |
| cyc_wdata_o | output | 32 | Data for write or special cycle |
| cyc_done_i | input | 1 | Initiator has finished the cycle |
| cyc_rdata_i | input | 32 | Read data from the initiator |

## Verification
Every result comes from a single register stage. A locally completed access shows its response on the first falling edge after the accepting edge. A translated access shows its request on that same edge. Its response appears on the falling edge after the edge that samples `cyc_done_i`. The bench drives requests on falling edges and samples exactly at these points. It holds done back for a random number of cycles and checks that the request stays unchanged meanwhile. The expected kind, command, address and data come from a bench model of the address register.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_CFG0    = 2'd0,
    KIND_CFG1    = 2'd1,
    KIND_SPECIAL = 2'd2,
    KIND_LOCAL   = 2'd3
  } cyc_kind_e;

  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [3:0] CMD_SPECIAL = 4'b0001;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] regn;
  } cfg_addr_t;

  function automatic logic [DATA_W-1:0] cfg_pack(cfg_addr_t c);
    return {c.en, 7'b0, c.bus, c.dev, c.fn, c.regn, 2'b00};
  endfunction

  function automatic cfg_addr_t cfg_unpack(logic [DATA_W-1:0] w);
    cfg_addr_t c;
    c.en   = w[31];
    c.bus  = w[23:16];
    c.dev  = w[15:11];
    c.fn   = w[10:8];
    c.regn = w[7:2];
    return c;
  endfunction
endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
  import cfgx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_addr_t         cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (we_i) cfg_o <= cfg_unpack(wdata_i);
  end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter logic [7:0]  LOCAL_BUS = 8'd0,
  parameter int unsigned IDSEL_LSB = 11,
  parameter int unsigned IDSEL_N   = 21
) (
  input  cfg_addr_t         cfg_i,
  input  logic              write_i,
  output cyc_kind_e         kind_o,
  output logic [3:0]        cmd_o,
  output logic [DATA_W-1:0] addr_o
);
  localparam int unsigned PAD_W = DATA_W - IDSEL_N;

  logic [IDSEL_N-1:0] idsel;
  logic [DATA_W-1:0]  idsel_word;
  logic [DATA_W-1:0]  addr0, addr1;

  for (genvar i = 0; i < IDSEL_N; i++) begin : g_idsel
    assign idsel[i] = (cfg_i.dev == 5'(i));
  end

  assign idsel_word = {{PAD_W{1'b0}}, idsel} << IDSEL_LSB;
  assign addr0 = idsel_word | {21'b0, cfg_i.fn, cfg_i.regn, 2'b00};
  assign addr1 = {8'h00, cfg_i.bus, cfg_i.dev, cfg_i.fn, cfg_i.regn, 2'b01};

  always_comb begin
    kind_o = KIND_LOCAL;
    cmd_o  = write_i ? CMD_CFG_WR : CMD_CFG_RD;
    addr_o = '0;
    if (!cfg_i.en) begin
      kind_o = KIND_LOCAL;
    end else if (cfg_i.bus != LOCAL_BUS) begin
      kind_o = KIND_CFG1;
      addr_o = addr1;
    end else if (&cfg_i.dev) begin
      // reserved device number: special cycle on writes only
      if (write_i) begin
        kind_o = KIND_SPECIAL;
        cmd_o  = CMD_SPECIAL;
      end
    end else begin
      kind_o = KIND_CFG0;
      addr_o = addr0;
    end
  end
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              hit_addr_i,
  input  logic              hit_data_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] cfg_word_i,
  input  cyc_kind_e         kind_i,
  input  logic [3:0]        cmd_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic              req_ready_o,
  output logic              cfg_we_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              cyc_valid_o,
  output cyc_kind_e         cyc_kind_o,
  output logic [3:0]        cyc_cmd_o,
  output logic [DATA_W-1:0] cyc_addr_o,
  output logic [DATA_W-1:0] cyc_wdata_o,
  input  logic              cyc_done_i,
  input  logic [DATA_W-1:0] cyc_rdata_i
);
  logic accept, go_bus, pend_write;
  logic [DATA_W-1:0] local_rdata;

  assign req_ready_o = !cyc_valid_o;
  assign accept      = req_valid_i && req_ready_o;
  assign cfg_we_o    = accept && req_write_i && hit_addr_i;
  assign go_bus      = hit_data_i && (kind_i != KIND_LOCAL);

  always_comb begin
    if (req_write_i)     local_rdata = '0;
    else if (hit_addr_i) local_rdata = cfg_word_i;
    else if (hit_data_i) local_rdata = '1;
    else                 local_rdata = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      cyc_valid_o <= 1'b0;
      cyc_kind_o  <= KIND_CFG0;
      cyc_cmd_o   <= '0;
      cyc_addr_o  <= '0;
      cyc_wdata_o <= '0;
      pend_write  <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (cyc_valid_o) begin
        if (cyc_done_i) begin
          cyc_valid_o <= 1'b0;
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= pend_write ? '0 : cyc_rdata_i;
        end
      end else if (accept) begin
        if (go_bus) begin
          cyc_valid_o <= 1'b1;
          cyc_kind_o  <= kind_i;
          cyc_cmd_o   <= cmd_i;
          cyc_addr_o  <= addr_i;
          cyc_wdata_o <= req_write_i ? req_wdata_i : '0;
          pend_write  <= req_write_i;
        end else begin
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= local_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
  import cfgx_pkg::*;
#(
  parameter int unsigned OFF_W     = 8,
  parameter logic [7:0]  ADDR_OFF  = 8'h00,
  parameter logic [7:0]  DATA_OFF  = 8'h04,
  parameter logic [7:0]  LOCAL_BUS = 8'd0,
  parameter int unsigned IDSEL_LSB = 11,
  parameter int unsigned IDSEL_N   = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [OFF_W-1:0]  req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              cyc_valid_o,
  output logic [1:0]        cyc_kind_o,
  output logic [3:0]        cyc_cmd_o,
  output logic [31:0]       cyc_addr_o,
  output logic [31:0]       cyc_wdata_o,
  input  logic              cyc_done_i,
  input  logic [31:0]       cyc_rdata_i
);
  localparam int unsigned WORD_W = OFF_W - 2;
  localparam logic [WORD_W-1:0] ADDR_WORD = ADDR_OFF[OFF_W-1:2];
  localparam logic [WORD_W-1:0] DATA_WORD = DATA_OFF[OFF_W-1:2];

  cfg_addr_t         cfg;
  cyc_kind_e         dec_kind, cyc_kind;
  logic [3:0]        dec_cmd;
  logic [DATA_W-1:0] dec_addr;
  logic              hit_addr, hit_data, cfg_we;

  // low two offset bits select a byte inside a word and never affect the hit
  assign hit_addr = (req_addr_i[OFF_W-1:2] == ADDR_WORD);
  assign hit_data = (req_addr_i[OFF_W-1:2] == DATA_WORD);

  cfgx_addr_reg u_addr_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we),
    .wdata_i (req_wdata_i),
    .cfg_o   (cfg)
  );

  cfgx_decode #(
    .LOCAL_BUS (LOCAL_BUS),
    .IDSEL_LSB (IDSEL_LSB),
    .IDSEL_N   (IDSEL_N)
  ) u_decode (
    .cfg_i   (cfg),
    .write_i (req_write_i),
    .kind_o  (dec_kind),
    .cmd_o   (dec_cmd),
    .addr_o  (dec_addr)
  );

  cfgx_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .hit_addr_i  (hit_addr),
    .hit_data_i  (hit_data),
    .req_wdata_i (req_wdata_i),
    .cfg_word_i  (cfg_pack(cfg)),
    .kind_i      (dec_kind),
    .cmd_i       (dec_cmd),
    .addr_i      (dec_addr),
    .req_ready_o (req_ready_o),
    .cfg_we_o    (cfg_we),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .cyc_valid_o (cyc_valid_o),
    .cyc_kind_o  (cyc_kind),
    .cyc_cmd_o   (cyc_cmd_o),
    .cyc_addr_o  (cyc_addr_o),
    .cyc_wdata_o (cyc_wdata_o),
    .cyc_done_i  (cyc_done_i),
    .cyc_rdata_i (cyc_rdata_i)
  );

  assign cyc_kind_o = cyc_kind;
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        cyc_valid_o,
  input logic [1:0]  cyc_kind_o,
  input logic [3:0]  cyc_cmd_o,
  input logic [31:0] cyc_addr_o,
  input logic        cyc_done_i
);
  a_r1_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && cyc_valid_o));

  a_r4_type0_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_kind_o == 2'd0 |->
      cyc_addr_o[1:0] == 2'b00 && $countones(cyc_addr_o[31:11]) <= 1);

  a_r5_type1_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_kind_o == 2'd1 |->
      cyc_addr_o[1:0] == 2'b01 && cyc_addr_o[31:24] == 8'h00);

  a_r6_cfg_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_kind_o != 2'd2 |-> cyc_cmd_o[3:1] == 3'b101);

  a_r7_special: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_kind_o == 2'd2 |-> cyc_cmd_o == 4'b0001 && cyc_addr_o == 32'h0);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && !cyc_done_i |=>
      cyc_valid_o && $stable(cyc_addr_o) && $stable(cyc_cmd_o) && $stable(cyc_kind_o));

  a_r9_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> !req_ready_o);

  a_r10_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_done_i |=> rsp_valid_o && !cyc_valid_o);
endmodule

bind cfgx_top cfgx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .cyc_valid_o (cyc_valid_o),
  .cyc_kind_o  (cyc_kind_o),
  .cyc_cmd_o   (cyc_cmd_o),
  .cyc_addr_o  (cyc_addr_o),
  .cyc_done_i  (cyc_done_i)
);

// File: tb/tb_cfgx_top.sv
`timescale 1ns/1ps
module tb_cfgx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, cyc_valid;
  logic [31:0] rsp_rdata, cyc_addr, cyc_wdata;
  logic [1:0]  cyc_kind;
  logic [3:0]  cyc_cmd;
  logic        cyc_done = 1'b0;
  logic [31:0] cyc_rdata = '0;

  int n_chk = 0, n_fail = 0;

  // bench model of the address register
  bit       m_en;
  bit [7:0] m_bus;
  bit [4:0] m_dev;
  bit [2:0] m_fn;
  bit [5:0] m_reg;

  always #4 clk = ~clk;

  cfgx_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cyc_valid_o(cyc_valid), .cyc_kind_o(cyc_kind), .cyc_cmd_o(cyc_cmd),
    .cyc_addr_o(cyc_addr), .cyc_wdata_o(cyc_wdata),
    .cyc_done_i(cyc_done), .cyc_rdata_i(cyc_rdata)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    return {m_en, 7'b0, m_bus, m_dev, m_fn, m_reg, 2'b00};
  endfunction

  function automatic logic [31:0] type0_addr();
    logic [31:0] a;
    a = {21'b0, m_fn, m_reg, 2'b00};
    if (m_dev <= 5'd20) a[11 + m_dev] = 1'b1;
    return a;
  endfunction

  task automatic run_access(bit wr, logic [7:0] a, logic [31:0] wd, string tag);
    bit          hit_a, hit_d, exp_cyc;
    logic [1:0]  exp_kind;
    logic [3:0]  exp_cmd;
    logic [31:0] exp_addr, exp_rd, rd;
    int          dly;
    hit_a = (a[7:2] == 6'd0);
    hit_d = (a[7:2] == 6'd1);
    exp_cyc = 0; exp_kind = 0; exp_addr = 0;
    exp_cmd = wr ? 4'b1011 : 4'b1010;
    exp_rd = wr ? 32'h0 : hit_a ? model_word() : hit_d ? 32'hFFFF_FFFF : 32'h0;
    if (hit_d && m_en) begin
      if (m_bus != 8'd0) begin
        exp_cyc = 1; exp_kind = 2'd1;
        exp_addr = {8'h00, m_bus, m_dev, m_fn, m_reg, 2'b01};
      end else if (m_dev == 5'd31) begin
        if (wr) begin
          exp_cyc = 1; exp_kind = 2'd2; exp_cmd = 4'b0001; exp_addr = 0;
        end
      end else begin
        exp_cyc = 1; exp_kind = 2'd0; exp_addr = type0_addr();
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (!exp_cyc) begin
      chk({tag, " local rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({tag, " no cyc_valid"}, 32'(cyc_valid), 32'd0);
      chk({tag, " local rdata"}, rsp_rdata, exp_rd);
    end else begin
      chk({tag, " cyc_valid"}, 32'(cyc_valid), 32'd1);
      chk({tag, " kind"}, 32'(cyc_kind), 32'(exp_kind));
      chk({tag, " R6 cmd"}, 32'(cyc_cmd), 32'(exp_cmd));
      chk({tag, " addr"}, cyc_addr, exp_addr);
      if (wr) chk({tag, " wdata"}, cyc_wdata, wd);
      dly = $urandom_range(0, 3);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk({tag, " R9 held addr"}, cyc_addr, exp_addr);
        chk({tag, " R9 ready low"}, 32'(req_ready), 32'd0);
        chk({tag, " R9 no early rsp"}, 32'(rsp_valid), 32'd0);
      end
      rd = $urandom;
      cyc_rdata = rd; cyc_done = 1;
      @(negedge clk);
      cyc_done = 0;
      chk({tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({tag, " R10 cyc dropped"}, 32'(cyc_valid), 32'd0);
      chk({tag, " R10 rdata"}, rsp_rdata, wr ? 32'h0 : rd);
    end
    if (wr && hit_a) begin
      m_en = wd[31]; m_bus = wd[23:16]; m_dev = wd[15:11];
      m_fn = wd[10:8]; m_reg = wd[7:2];
    end
  endtask

  function automatic logic [31:0] mk(bit en, logic [7:0] bus, logic [4:0] dev,
                                     logic [2:0] fn, logic [5:0] rg);
    return {en, 7'h55, bus, dev, fn, rg, 2'b11};
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    m_en = 0; m_bus = 0; m_dev = 0; m_fn = 0; m_reg = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 no cyc after reset", 32'(cyc_valid), 32'd0);
    chk("R1 no rsp after reset", 32'(rsp_valid), 32'd0);
    rst_n = 1;
    run_access(0, 8'h00, 0, "R1 addr reg reset value");

    run_access(1, 8'h00, 32'hFFFF_FFFF, "R2 write all ones");
    run_access(0, 8'h03, 0, "R2 readback reserved zero");
    chk("R2 packed value", model_word(), 32'h80FF_FFFC);

    run_access(1, 8'h00, mk(0, 8'h00, 5'd3, 3'd1, 6'd4), "R3 setup");
    run_access(0, 8'h04, 0, "R3 disabled read");
    run_access(1, 8'h05, 32'h1234_5678, "R3 disabled write");

    run_access(1, 8'h00, mk(1, 8'h00, 5'd0, 3'd2, 6'd9), "R4 setup dev0");
    run_access(0, 8'h04, 0, "R4 type0 dev0");
    run_access(1, 8'h00, mk(1, 8'h00, 5'd20, 3'd7, 6'd63), "R4 setup dev20");
    run_access(1, 8'h06, 32'hA5A5_0001, "R4 type0 dev20 write");
    run_access(1, 8'h00, mk(1, 8'h00, 5'd21, 3'd0, 6'd1), "R4 setup dev21");
    run_access(0, 8'h07, 0, "R12 R4 type0 no idsel");

    run_access(1, 8'h00, mk(1, 8'h03, 5'd5, 3'd4, 6'd17), "R5 setup");
    run_access(0, 8'h04, 0, "R5 type1 read");
    run_access(1, 8'h00, mk(1, 8'h00, 5'd31, 3'd7, 6'd0), "R7 setup");
    run_access(1, 8'h04, 32'hDEAD_BEEF, "R7 special write");
    run_access(0, 8'h05, 0, "R8 reserved dev read");
    run_access(1, 8'h00, mk(1, 8'h02, 5'd31, 3'd7, 6'd0), "R5 setup remote dev31");
    run_access(0, 8'h04, 0, "R5 remote dev31 type1");

    run_access(1, 8'h20, 32'h0000_0000, "R11 unmapped write");
    run_access(0, 8'h21, 0, "R11 unmapped read");
    run_access(0, 8'h00, 0, "R11 addr reg unchanged");

    for (int n = 0; n < 80; n++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 1) == 0) w[23:16] = 8'h00;
      if ($urandom_range(0, 3) == 0) w[15:11] = 5'd31;
      run_access(1, 8'h00, w, "R2 random setup");
      run_access(bit'($urandom_range(0, 1)), {6'd1, 2'($urandom)}, $urandom,
                 "R4 R5 R7 random data access");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule